// File: doc/BRIEF.md
# Packed SIMD add-subtract unit

This unit performs lane-parallel addition and subtraction on two 32-bit operands. A single opcode chooses the lane shape: four byte lanes, two halfword lanes or one full word. It also chooses signed or unsigned arithmetic and one of three result treatments: modular wrap, clamp to the lane range, or the full-precision result shifted right by one. Two exchange forms pair each halfword of `op_a` with the opposite halfword of `op_b`. One half adds and the other subtracts.

Wrap-mode operations also produce four byte-granular greater-or-equal flags, which are kept in a flag register. A select operation then builds a word byte by byte, taking each byte from `op_a` or `op_b` according to the stored flag. The result and the flags are registered. They update on the clock edge where `valid_in` is high and hold their value otherwise.

Opcode layout: bits [1:0] give the shape (0 = bytes, 1 = halfwords, 2 = word, 3 = byte select). Bits [3:2] give the arithmetic (0 = add, 1 = subtract, 2 = exchange with upper add and lower subtract, 3 = exchange with upper subtract and lower add). Any exchange code forces halfword lanes. Bits [5:4] give the mode (0 or 3 = wrap, 1 = saturate, 2 = halve). Bit [6] selects signed arithmetic.

Top module: `simd_addsub`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and `ge_flags` to zero on the next clock edge.
- R2: `result` and `ge_flags` take their new values on the first rising edge where `valid_in` is high, and keep their values on edges where `valid_in` is low.
- R3: In wrap mode, each byte, halfword or word lane returns its sum or difference modulo 2^n, with no carry or borrow between lanes.
- R4: In signed saturate mode (bit 6 = 1, mode 1), each n-bit lane result is clamped to the range from -2^(n-1) to 2^(n-1)-1.
- R5: In unsigned saturate mode (bit 6 = 0, mode 1), each lane result is clamped to the range 0 to 2^n-1.
- R6: In halve mode, each lane returns its full-precision (n+1 bit) sum or difference shifted right by one. The shift is arithmetic for signed lanes. For unsigned lanes it includes the borrow bit, so an unsigned difference with a < b halves to a value with its top bit set.
- R7: The exchange code 2 gives upper = a[31:16] + b[15:0] and lower = a[15:0] - b[31:16]. Code 3 gives upper = a[31:16] - b[15:0] and lower = a[15:0] + b[31:16]. Both take the selected mode and signedness.
- R8: A wrap-mode operation writes one flag per byte. The flag is set when the lane's full-precision result is non-negative (for signed operations and for unsigned subtract) or when the lane carries out (for unsigned add). A halfword lane drives both of its byte flags, and a word lane drives all four.
- R9: Saturate-mode, halve-mode and select operations leave `ge_flags` unchanged.
- R10: The select operation (shape 3) returns byte i of `op_a` when stored flag i is set, and byte i of `op_b` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present; registers update on this edge |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 7 | Shape [1:0], arithmetic [3:2], mode [5:4], signed [6] |
| result | output | 32 | Registered result |
| ge_flags | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
The state that is hardest to reach from the ports is a select whose outcome depends on a particular flag pattern, because that pattern has to be left behind by an earlier wrap operation. A saturate or halve operation in between must not disturb it. Directed sequences first establish flags 0b0001 through a signed byte add. They then issue a saturating operation and check that the flags survive, issue a select, change the flags to 0b0010 and select again. A long random run mixes every opcode with operands biased toward lane sign bits, so that saturation, exchange borrows and flag-then-select chains occur often.

// File: rtl/simd_addsub.sv
module simd_addsub (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_in,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [6:0]  opcode,
  output logic [31:0] result,
  output logic [3:0]  ge_flags
);

  logic [1:0] shape, arith, mode;
  logic       sgn, xchg, is_sel, flag_wr, sub_hi, sub_lo;
  logic [31:0] b_x;
  logic [35:0] c8, c16, c32;
  logic [31:0] nxt_res;
  logic [3:0]  nxt_flags;

  assign shape   = opcode[1:0];
  assign arith   = opcode[3:2];
  assign mode    = opcode[5:4];
  assign sgn     = opcode[6];
  assign xchg    = arith[1];
  assign is_sel  = (shape == 2'd3);
  assign flag_wr = !is_sel && (mode == 2'd0 || mode == 2'd3);
  assign sub_hi  = arith[0];
  assign sub_lo  = arith[0] ^ xchg;
  assign b_x     = xchg ? {op_b[15:0], op_b[31:16]} : op_b;

  // returns {flags[3:0], result[31:0]} for lanes of width w
  function automatic logic [35:0] calc(input logic [31:0] a, input logic [31:0] b,
                                       input int w, input logic shi, input logic slo,
                                       input logic sg, input logic [1:0] md);
    logic [31:0] m, x, y, res;
    logic signed [33:0] ex, ey, s, hi, lo, r;
    logic [3:0] lf, fl;
    logic sub;
    res = '0;
    lf  = '0;
    m   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    for (int k = 0; k < 4; k++) begin
      if (k < 32 / w) begin
        x  = (a >> (k * w)) & m;
        y  = (b >> (k * w)) & m;
        ex = {2'b00, x};
        ey = {2'b00, y};
        if (sg && x[w-1]) ex = ex | (~34'd0 << w);
        if (sg && y[w-1]) ey = ey | (~34'd0 << w);
        sub = (k >= (32 / w) / 2) ? shi : slo;
        s   = sub ? ex - ey : ex + ey;
        hi  = sg ? (34'sd1 <<< (w - 1)) - 34'sd1 : (34'sd1 <<< w) - 34'sd1;
        lo  = sg ? -(34'sd1 <<< (w - 1)) : 34'sd0;
        lf[k] = (sg || sub) ? (s >= 34'sd0) : (s > hi);
        case (md)
          2'd1:    r = (s > hi) ? hi : ((s < lo) ? lo : s);
          2'd2:    r = s >>> 1;
          default: r = s;
        endcase
        res = res | ((r[31:0] & m) << (k * w));
      end
    end
    for (int i = 0; i < 4; i++) fl[i] = lf[(i * 8) / w];
    return {fl, res};
  endfunction

  assign c8  = calc(op_a, op_b, 8,  sub_hi, sub_hi, sgn, mode);
  assign c16 = calc(op_a, b_x,  16, sub_hi, sub_lo, sgn, mode);
  assign c32 = calc(op_a, op_b, 32, sub_hi, sub_hi, sgn, mode);

  always_comb begin
    nxt_res   = c32[31:0];
    nxt_flags = c32[35:32];
    if (is_sel) begin
      for (int i = 0; i < 4; i++)
        nxt_res[i*8 +: 8] = ge_flags[i] ? op_a[i*8 +: 8] : op_b[i*8 +: 8];
      nxt_flags = ge_flags;
    end else if (xchg || shape == 2'd1) begin
      nxt_res   = c16[31:0];
      nxt_flags = c16[35:32];
    end else if (shape == 2'd0) begin
      nxt_res   = c8[31:0];
      nxt_flags = c8[35:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      ge_flags <= '0;
    end else if (valid_in) begin
      result <= nxt_res;
      if (flag_wr) ge_flags <= nxt_flags;
    end
  end

endmodule

module simd_addsub_chk (
  input logic        clk,
  input logic        rst,
  input logic        valid_in,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [6:0]  opcode,
  input logic [31:0] result,
  input logic [3:0]  ge_flags
);

  function automatic logic [31:0] pick(input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    for (int i = 0; i < 4; i++) pick[i*8 +: 8] = f[i] ? a[i*8 +: 8] : b[i*8 +: 8];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (result == 32'd0 && ge_flags == 4'd0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !valid_in |=> ($stable(result) && $stable(ge_flags))); // R2
  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_in && (opcode[1:0] == 2'd3 || opcode[5:4] == 2'd1 || opcode[5:4] == 2'd2)) |=> $stable(ge_flags)); // R9
  AST_HALF_PAIRS: assert property (@(posedge clk) disable iff (rst)
    (valid_in && opcode[1:0] != 2'd3 && (opcode[1:0] == 2'd1 || opcode[3]) && (opcode[5:4] == 2'd0 || opcode[5:4] == 2'd3))
    |=> (ge_flags[1] == ge_flags[0] && ge_flags[3] == ge_flags[2])); // R8
  AST_SELECT_BYTES: assert property (@(posedge clk) disable iff (rst)
    (valid_in && opcode[1:0] == 2'd3) |=> (result == pick($past(op_a), $past(op_b), $past(ge_flags)))); // R10
  AST_USAT_WORD_GE: assert property (@(posedge clk) disable iff (rst)
    (valid_in && opcode == 7'b0010010) |=> (result >= $past(op_a))); // R5

endmodule

bind simd_addsub simd_addsub_chk u_chk (.*);

// File: tb/test_simd_addsub.sv
module test_simd_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [6:0]  opcode = '0;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags = '0;

  simd_addsub i_simd_addsub (.clk(clk), .rst(rst), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
                             .opcode(opcode), .result(result), .ge_flags(ge_flags));

  always #2 clk = ~clk;

  function automatic logic [6:0] mk(input logic sg, input logic [1:0] md, input logic [1:0] ar, input logic [1:0] sh);
    return {sg, md, ar, sh};
  endfunction

  // reference: {flags, result}
  function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b, input logic [6:0] op, input logic [3:0] fin);
    int w, n;
    longint x, y, s, r, mx, mn, msk;
    logic [31:0] res;
    logic [3:0] fo, lf;
    logic sub, sg;
    logic [1:0] sh, ar, md;
    sh = op[1:0]; ar = op[3:2]; md = op[5:4]; sg = op[6];
    res = '0; lf = '0;
    if (sh == 2'd3) begin
      for (int i = 0; i < 4; i++) res[i*8 +: 8] = fin[i] ? a[i*8 +: 8] : b[i*8 +: 8];
      return {fin, res};
    end
    w = ar[1] ? 16 : (sh == 2'd0 ? 8 : (sh == 2'd1 ? 16 : 32));
    n = 32 / w;
    msk = (64'sd1 << w) - 1;
    for (int k = 0; k < n; k++) begin
      x = (longint'(a) >> (k * w)) & msk;
      if (ar[1]) y = (longint'(b) >> ((1 - k) * w)) & msk;
      else       y = (longint'(b) >> (k * w)) & msk;
      if (sg && x >= (64'sd1 << (w - 1))) x = x - (64'sd1 << w);
      if (sg && y >= (64'sd1 << (w - 1))) y = y - (64'sd1 << w);
      if (ar == 2'd2)      sub = (k == 0);
      else if (ar == 2'd3) sub = (k == 1);
      else                 sub = ar[0];
      s = sub ? x - y : x + y;
      mx = sg ? (64'sd1 << (w - 1)) - 1 : msk;
      mn = sg ? -(64'sd1 << (w - 1)) : 0;
      lf[k] = (sg || sub) ? (s >= 0) : (s > msk);
      if (md == 2'd1)      r = (s > mx) ? mx : ((s < mn) ? mn : s);
      else if (md == 2'd2) r = s >>> 1;
      else                 r = s;
      res = res | 32'((r & msk) << (k * w));
    end
    for (int i = 0; i < 4; i++) fo[i] = lf[(i * 8) / w];
    if (md == 2'd1 || md == 2'd2) fo = fin;
    return {fo, res};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b, input logic [6:0] op,
                     input logic use_exp, input logic [31:0] exp);
    logic [35:0] e;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; valid_in = 1'b1;
    e = model(a, b, op, mflags);
    @(negedge clk);
    valid_in = 1'b0;
    mflags = e[35:32];
    chk(req, result, e[31:0]);
    chk(req, {28'd0, ge_flags}, {28'd0, mflags});
    if (use_exp) chk(req, result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset result", result, 32'd0);
    chk("R1 reset flags", {28'd0, ge_flags}, 32'd0);

    run("R3 byte wrap add", 32'h07050301, 32'h08060402, mk(0, 0, 0, 0), 1, 32'h0F0B0703);
    run("R3 word wrap add", 32'hFFFFFFFF, 32'h00000001, mk(0, 0, 0, 2), 1, 32'h00000000);
    run("R3 half wrap sub", 32'h00030006, 32'h00020004, mk(0, 0, 1, 1), 1, 32'h00010002);
    run("R4 word sat add", 32'h80000000, 32'h80000002, mk(1, 1, 0, 2), 1, 32'h80000000);
    run("R4 word sat sub", 32'h80000003, 32'h00000004, mk(1, 1, 1, 2), 1, 32'h80000000);
    run("R4 byte sat add", 32'h8085837F, 32'hFF060402, mk(1, 1, 0, 0), 1, 32'h808B877F);
    run("R5 unsigned sat exchange", 32'hFFF80003, 32'h00040009, mk(0, 1, 2, 1), 1, 32'hFFFF0000);
    run("R5 byte unsigned sat sub", 32'h080B0702, 32'h0F060408, mk(0, 1, 1, 0), 1, 32'h00050300);
    run("R6 signed halve sub", 32'h8F8B8783, 32'h08060402, mk(1, 2, 1, 0), 1, 32'hC3C2C1C0);
    run("R6 unsigned halve sub a<b", 32'h00000002, 32'h00000004, mk(0, 2, 1, 0), 1, 32'h000000FF);
    run("R7 exchange add-hi wrap", 32'h80078003, 32'h00040002, mk(1, 0, 2, 1), 1, 32'h80097FFF);
    run("R7 exchange add-hi sat", 32'h80078003, 32'h00040002, mk(1, 1, 2, 1), 1, 32'h80098000);
    run("R7 exchange sub-hi wrap", 32'h80038007, 32'h00020004, mk(1, 0, 3, 1), 1, 32'h7FFF8009);
    run("R8 byte signed add flags", 32'h80808000, 32'h00000000, mk(1, 0, 0, 0), 0, 32'h0);
    chk("R8 flags 0001", {28'd0, ge_flags}, 32'h1);
    run("R9 saturate keeps flags", 32'h12345678, 32'h87654321, mk(1, 1, 0, 0), 0, 32'h0);
    chk("R9 flags still 0001", {28'd0, ge_flags}, 32'h1);
    run("R10 select flags 0001", 32'h33221100, 32'h77665544, mk(0, 0, 0, 3), 1, 32'h77665500);
    run("R8 byte signed add flags", 32'h80800080, 32'h00000000, mk(1, 0, 0, 0), 0, 32'h0);
    run("R10 select flags 0010", 32'h33221100, 32'h77665544, mk(0, 0, 0, 3), 1, 32'h77661144);
    run("R8 half unsigned sub flags", 32'h00020006, 32'h00030004, mk(0, 0, 1, 1), 0, 32'h0);
    chk("R8 half flag pairs", {28'd0, ge_flags}, 32'h3);

    held = result;
    @(negedge clk);
    op_a = 32'hDEADBEEF; op_b = 32'h01234567; opcode = mk(0, 0, 0, 2);
    repeat (2) @(negedge clk);
    chk("R2 idle hold result", result, held);
    chk("R2 idle hold flags", {28'd0, ge_flags}, {28'd0, mflags});

    for (int it = 0; it < 600; it++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 3) == 0) a = a | 32'h80808080;
      if ($urandom_range(0, 3) == 0) b = b | 32'h80808080;
      if ($urandom_range(0, 7) == 0) a = 32'hFFFFFFFF;
      run("random", a, b, 7'($urandom()), 0, 32'h0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule